// File: doc/BRIEF.md
# Branch Trace Packet Encoder

This block watches retired branches from a processor core and turns them into a compact byte stream of trace packets. Each accepted event carries a branch kind, a taken flag, the address of the branch, its target and whether it ran in kernel or user mode. Conditional branches become single bits that are grouped into one-byte bundles of up to six. Indirect jumps, calls and returns become a target packet. Direct branches produce nothing, because their targets are known statically. Every packet group that goes out starts with a timing byte. That byte holds the number of clock cycles since the previous timing byte.

The packet bytes are written into an internal circular byte buffer. When the buffer is full, new bytes replace the oldest ones, so the buffer always holds the most recent history. A consumer drains the buffer through a byte-wide valid/ready port. Tracing can be switched off globally, limited to user or kernel code, and limited to a set of inclusive address windows on the branch address. Events are accepted one per cycle while the packet serializer is nearly empty.

Top module: `brtrace_enc`

## Requirements
- R1: Six traced conditional branches produce one bundle byte after a timing byte. In the bundle, bit 0 is 0, the branch bits sit above it with the oldest in the highest position (1 = taken), and a stop bit of 1 sits just above the oldest bit. T,N,N,N,N,N gives 0xC0 and N,T,T,N,T,T gives 0xB6.
- R2: A direct branch (kind 0) produces no output byte and leaves the bundle untouched.
- R3: An indirect branch (kind 2) or a return (kind 3) produces a header byte whose low five bits are 5'b01101. When no earlier target exists, or the upper 16 target bits differ from the last emitted target, the mode bits [7:5] are 3'b110 (header 0xCD) and all ADDR_W/8 target bytes follow, least significant first.
- R4: When the upper 16 target bits equal the last emitted target, the mode bits are 3'b001 (header 0x2D) and only the low two target bytes follow, least significant first.
- R5: A partially filled bundle is emitted after the timing byte and before the header of an indirect packet.
- R6: Every packet group starts with a timing byte. Its bits [1:0] are 2'b11 and bit 2 is 0, and bits [7:3] hold the cycle count. The count is the number of clock edges from the previous group's acceptance edge (or from reset release) to this group's acceptance edge.
- R7: A count above 31 sets bit 2 of the timing byte and appends one extension byte holding count bits [12:5]. The count saturates at 8191.
- R8: A kernel-mode event is traced only when kernel tracing is enabled, and a user-mode event only when user tracing is enabled.
- R9: When any address window is enabled, an event is traced only if its branch address lies inside an enabled window, with both bounds inclusive.
- R10: When tracing is switched off, a partial bundle is emitted (timing byte plus bundle) at once. Events that arrive while tracing is off are ignored.
- R11: The buffer keeps the latest DEPTH bytes in order. When a byte arrives while it is full, the oldest byte is dropped.
- R12: After reset out_valid is 0 and ev_ready is 1. While out_valid is high and out_ready is low, out_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Global trace enable |
| cfg_user_en | input | 1 | Trace user-mode branches |
| cfg_kern_en | input | 1 | Trace kernel-mode branches |
| cfg_win_en | input | NWIN | Per-window enable for address filtering |
| cfg_win_lo | input | NWIN*ADDR_W | Inclusive lower bounds, window i at bits [i*ADDR_W +: ADDR_W] |
| cfg_win_hi | input | NWIN*ADDR_W | Inclusive upper bounds, same packing |
| ev_valid | input | 1 | Branch event present |
| ev_ready | output | 1 | Event accepted on this edge when valid |
| ev_kind | input | 2 | 0 direct, 1 conditional, 2 indirect, 3 return |
| ev_taken | input | 1 | Conditional outcome, 1 = taken |
| ev_kern | input | 1 | 1 = kernel mode |
| ev_pc | input | ADDR_W | Address of the branch |
| ev_tgt | input | ADDR_W | Branch target |
| out_valid | output | 1 | Buffer holds a byte |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Oldest byte in the buffer |

## Verification
The bench builds the encoder with ADDR_W = 32 and two address windows, and shrinks the buffer to DEPTH = 8. With that buffer size, one stall of three full indirect packets (18 bytes) laps the buffer more than twice, which exercises the overwrite path. The 32-bit address width gives the full-address header four target bytes. It also lets targets share or differ in their upper half, so that both header modes appear. One idle stretch of about 9000 cycles drives the cycle count past its 8191 ceiling.

// File: rtl/brtrace_pkg.sv
`timescale 1ns/1ps
package brtrace_pkg;
  typedef enum logic [1:0] {
    BK_DIRECT = 2'd0,
    BK_COND   = 2'd1,
    BK_INDIR  = 2'd2,
    BK_RET    = 2'd3
  } br_kind_e;

  localparam int          CYC_W      = 13;
  localparam int          BUNDLE_MAX = 6;
  localparam logic [4:0]  TGT_TAG    = 5'b01101;
  localparam logic [2:0]  MODE_LOW16 = 3'b001;
  localparam logic [2:0]  MODE_WHOLE = 3'b110;
endpackage

// File: rtl/brtrace_filter.sv
`timescale 1ns/1ps
module brtrace_filter #(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 2
) (
  input  logic                   trc_en,
  input  logic                   cfg_user_en,
  input  logic                   cfg_kern_en,
  input  logic [NWIN-1:0]        cfg_win_en,
  input  logic [NWIN*ADDR_W-1:0] cfg_win_lo,
  input  logic [NWIN*ADDR_W-1:0] cfg_win_hi,
  input  logic                   ev_kern,
  input  logic [ADDR_W-1:0]      ev_pc,
  output logic                   pass
);
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ADDR_W-1:0] lo, hi;
    assign lo     = cfg_win_lo[w*ADDR_W +: ADDR_W];
    assign hi     = cfg_win_hi[w*ADDR_W +: ADDR_W];
    assign hit[w] = cfg_win_en[w] && (ev_pc >= lo) && (ev_pc <= hi);
  end

  logic mode_ok, addr_ok;
  assign mode_ok = ev_kern ? cfg_kern_en : cfg_user_en;
  assign addr_ok = (cfg_win_en == '0) || (hit != '0);
  assign pass    = trc_en && mode_ok && addr_ok;
endmodule

// File: rtl/brtrace_pack.sv
`timescale 1ns/1ps
module brtrace_pack
  import brtrace_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trc_en,
  input  logic              acc,
  input  logic [1:0]        kind,
  input  logic              taken,
  input  logic [ADDR_W-1:0] tgt,
  output logic              ready,
  output logic              load,
  output logic [2:0]        bcnt_o,
  output logic              wr_valid,
  output logic [7:0]        wr_byte
);
  localparam int AB   = ADDR_W / 8;
  localparam int MAXB = 2 + 1 + 1 + AB;
  localparam int NW   = $clog2(MAXB + 1);
  localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

  logic [5:0]        bits;
  logic [2:0]        bcnt;
  logic [CYC_W-1:0]  cyc;
  logic [ADDR_W-1:0] last_tgt;
  logic              last_ok;
  logic [7:0]        pkt [MAXB];
  logic [NW-1:0]     rem;

  logic [7:0]        nb [MAXB];
  logic [NW-1:0]     nn;
  logic              cond_ev, ind_ev, full6, flush_off, short_tgt;
  logic [5:0]        n_bits;
  logic [2:0]        n_cnt;

  function automatic logic [7:0] enc(input logic [5:0] b, input logic [2:0] n);
    logic [7:0] r;
    r = '0;
    r[int'(n) + 1] = 1'b1;
    for (int i = 0; i < BUNDLE_MAX; i++)
      if (i < int'(n)) r[i + 1] = b[i];
    return r;
  endfunction

  assign ready     = (rem <= NW'(1));
  assign cond_ev   = acc && (kind == BK_COND);
  assign ind_ev    = acc && ((kind == BK_INDIR) || (kind == BK_RET));
  assign n_bits    = {bits[4:0], taken};
  assign n_cnt     = bcnt + 3'd1;
  assign full6     = cond_ev && (n_cnt == 3'(BUNDLE_MAX));
  assign flush_off = !trc_en && (bcnt != 3'd0) && ready;
  assign load      = full6 || ind_ev || flush_off;
  assign short_tgt = last_ok && (tgt[ADDR_W-1:16] == last_tgt[ADDR_W-1:16]);
  assign bcnt_o    = bcnt;

  always_comb begin
    int idx;
    for (int i = 0; i < MAXB; i++) nb[i] = 8'h00;
    idx = 0;
    if (cyc < CYC_W'(32)) begin
      nb[0] = {cyc[4:0], 3'b011};
      idx = 1;
    end else begin
      nb[0] = {cyc[4:0], 3'b111};
      nb[1] = cyc[12:5];
      idx = 2;
    end
    if (full6) begin
      nb[idx] = enc(n_bits, 3'(BUNDLE_MAX));
      idx = idx + 1;
    end else if (bcnt != 3'd0 && (ind_ev || flush_off)) begin
      nb[idx] = enc(bits, bcnt);
      idx = idx + 1;
    end
    if (ind_ev) begin
      nb[idx] = {short_tgt ? MODE_LOW16 : MODE_WHOLE, TGT_TAG};
      idx = idx + 1;
      for (int j = 0; j < AB; j++) begin
        if (!short_tgt || j < 2) begin
          nb[idx] = tgt[8*j +: 8];
          idx = idx + 1;
        end
      end
    end
    nn = NW'(idx);
  end

  assign wr_valid = (rem != '0);
  assign wr_byte  = pkt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      for (int i = 0; i < MAXB; i++) pkt[i] <= 8'h00;
    end else if (load) begin
      rem <= nn;
      for (int i = 0; i < MAXB; i++) pkt[i] <= nb[i];
    end else if (rem != '0) begin
      rem <= rem - NW'(1);
      for (int i = 0; i < MAXB - 1; i++) pkt[i] <= pkt[i + 1];
      pkt[MAXB-1] <= 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc      <= CYC_W'(1);
      bits     <= '0;
      bcnt     <= '0;
      last_tgt <= '0;
      last_ok  <= 1'b0;
    end else begin
      if (load)               cyc <= CYC_W'(1);
      else if (cyc != CYC_MAX) cyc <= cyc + CYC_W'(1);

      if (load) begin
        bcnt <= '0;
        bits <= '0;
      end else if (cond_ev) begin
        bcnt <= n_cnt;
        bits <= n_bits;
      end

      if (ind_ev) begin
        last_tgt <= tgt;
        last_ok  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/brtrace_ring.sv
`timescale 1ns/1ps
module brtrace_ring #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [7:0]                 wr_byte,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [7:0]                 out_byte,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = (fill == FW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_byte  = mem[rp];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_valid) mem[wp] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_valid) wp <= nxt(wp);
      if (pop || (wr_valid && full)) rp <= nxt(rp);
      if (wr_valid && !pop && !full) fill <= fill + FW'(1);
      else if (!wr_valid && pop)     fill <= fill - FW'(1);
    end
  end
endmodule

// File: rtl/brtrace_enc.sv
`timescale 1ns/1ps
module brtrace_enc #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int NWIN   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trc_en,
  input  logic                   cfg_user_en,
  input  logic                   cfg_kern_en,
  input  logic [NWIN-1:0]        cfg_win_en,
  input  logic [NWIN*ADDR_W-1:0] cfg_win_lo,
  input  logic [NWIN*ADDR_W-1:0] cfg_win_hi,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic [1:0]             ev_kind,
  input  logic                   ev_taken,
  input  logic                   ev_kern,
  input  logic [ADDR_W-1:0]      ev_pc,
  input  logic [ADDR_W-1:0]      ev_tgt,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_byte
);
  localparam int FW = $clog2(DEPTH + 1);

  logic          pass, acc, pk_load, pk_wr;
  logic [2:0]    pk_bcnt;
  logic [7:0]    pk_byte;
  logic [FW-1:0] ring_fill;

  brtrace_filter #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_filt (
    .trc_en(trc_en), .cfg_user_en(cfg_user_en), .cfg_kern_en(cfg_kern_en),
    .cfg_win_en(cfg_win_en), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
    .ev_kern(ev_kern), .ev_pc(ev_pc), .pass(pass)
  );

  assign acc = ev_valid && ev_ready && pass;

  brtrace_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst(rst), .trc_en(trc_en), .acc(acc), .kind(ev_kind),
    .taken(ev_taken), .tgt(ev_tgt), .ready(ev_ready), .load(pk_load),
    .bcnt_o(pk_bcnt), .wr_valid(pk_wr), .wr_byte(pk_byte)
  );

  brtrace_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .wr_valid(pk_wr), .wr_byte(pk_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
    .fill(ring_fill)
  );
endmodule

// File: rtl/brtrace_enc_chk.sv
`timescale 1ns/1ps
module brtrace_enc_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       trc_en,
  input logic                       ev_valid,
  input logic                       ev_ready,
  input logic [1:0]                 ev_kind,
  input logic                       pk_load,
  input logic [2:0]                 pk_bcnt,
  input logic                       pk_wr,
  input logic [$clog2(DEPTH+1)-1:0] ring_fill,
  input logic                       out_valid,
  input logic                       out_ready
);
  p_bundle_cap_r1: assert property (@(posedge clk) disable iff (rst)
    pk_bcnt <= 3'd5);

  p_direct_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind == 2'd0 && trc_en) |-> !pk_load);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!trc_en && pk_bcnt == 3'd0) |-> !pk_load);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    ring_fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_write_lands_r11: assert property (@(posedge clk) disable iff (rst)
    pk_wr |=> out_valid);

  p_hold_valid_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
endmodule

bind brtrace_enc brtrace_enc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .trc_en(trc_en), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .ev_kind(ev_kind), .pk_load(pk_load),
  .pk_bcnt(pk_bcnt), .pk_wr(pk_wr), .ring_fill(ring_fill),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/brtrace_enc_bench.sv
`timescale 1ns/1ps
module brtrace_enc_bench;
  localparam int AW = 32, DEPTH = 8, NWIN = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic trc_en = 1'b1, cfg_user_en = 1'b1, cfg_kern_en = 1'b1;
  logic [NWIN-1:0] cfg_win_en = '0;
  logic [NWIN*AW-1:0] cfg_win_lo = '0, cfg_win_hi = '0;
  logic ev_valid = 1'b0, ev_taken = 1'b0, ev_kern = 1'b0, out_ready = 1'b1;
  logic [1:0] ev_kind = 2'd0;
  logic [AW-1:0] ev_pc = '0, ev_tgt = '0;
  logic ev_ready, out_valid;
  logic [7:0] out_byte;

  always #5 clk = ~clk;

  brtrace_enc #(.ADDR_W(AW), .DEPTH(DEPTH), .NWIN(NWIN)) u_brtrace_enc (
    .clk(clk), .rst(rst), .trc_en(trc_en), .cfg_user_en(cfg_user_en),
    .cfg_kern_en(cfg_kern_en), .cfg_win_en(cfg_win_en), .cfg_win_lo(cfg_win_lo),
    .cfg_win_hi(cfg_win_hi), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_taken(ev_taken), .ev_kern(ev_kern), .ev_pc(ev_pc),
    .ev_tgt(ev_tgt), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte)
  );

  int checks = 0, errors = 0, edge_no = 0, last_emit = 0, nout = 0;
  bit done = 0;
  logic [7:0] exp_b [$];
  int         exp_r [$];
  bit         mbits [$];
  logic [AW-1:0] last_t = '0;
  bit last_ok = 0;

  always @(posedge clk) edge_no <= rst ? 0 : edge_no + 1;

  task automatic check(input bit ok, input int r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %0h expected %0h", r, act, exp);
    end
  endtask

  // Scoreboard monitor: every byte leaving the buffer is compared in order.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      nout++;
      if (exp_b.size() == 0) check(0, 11, out_byte, 'h100);
      else begin
        logic [7:0] e; int r;
        e = exp_b.pop_front(); r = exp_r.pop_front();
        check(out_byte == e, r, out_byte, e);
      end
    end
  end

  task automatic push(input logic [7:0] b, input int r);
    exp_b.push_back(b); exp_r.push_back(r);
  endtask

  // R6 / R7 expected timing bytes
  task automatic emit_timing(input int e, input int r);
    logic [31:0] d;
    d = e - last_emit;
    if (d > 8191) d = 8191;
    last_emit = e;
    if (d <= 31) push({d[4:0], 3'b011}, r);
    else begin push({d[4:0], 3'b111}, r); push(d[12:5], r); end
  endtask

  // R1 bundle layout: stop bit above the oldest bit, bit 0 clear
  function automatic logic [7:0] enc_bundle();
    logic [7:0] v; int n;
    n = mbits.size(); v = '0; v[n+1] = 1'b1;
    for (int i = 0; i < n; i++) v[n-i] = mbits[i];
    return v;
  endfunction

  function automatic bit traced(input logic kern, input logic [AW-1:0] pc);
    bit inwin;
    inwin = (cfg_win_en == '0);
    for (int w = 0; w < NWIN; w++)
      if (cfg_win_en[w] && pc >= cfg_win_lo[w*AW +: AW] && pc <= cfg_win_hi[w*AW +: AW]) inwin = 1;
    return trc_en && (kern ? cfg_kern_en : cfg_user_en) && inwin;
  endfunction

  task automatic send(input logic [1:0] k, input logic tk, input logic kern,
                      input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input int r);
    int e;
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    e = edge_no + 1;
    ev_kind = k; ev_taken = tk; ev_kern = kern; ev_pc = pc; ev_tgt = tgt; ev_valid = 1'b1;
    if (traced(kern, pc)) begin
      if (k == 2'd1) begin
        mbits.push_back(tk);
        if (mbits.size() == 6) begin
          emit_timing(e, r); push(enc_bundle(), r); mbits.delete();
        end
      end else if (k >= 2'd2) begin
        bit sh;
        sh = last_ok && (tgt[AW-1:16] == last_t[AW-1:16]);
        emit_timing(e, r);
        if (mbits.size() != 0) begin push(enc_bundle(), 5); mbits.delete(); end // R5
        if (sh) begin push(8'h2D, 4); push(tgt[7:0], 4); push(tgt[15:8], 4); end // R4
        else begin
          push(8'hCD, 3); // R3
          for (int j = 0; j < AW/8; j++) push(tgt[8*j +: 8], 3);
        end
        last_t = tgt; last_ok = 1;
      end
    end
    @(posedge clk); #1 ev_valid = 1'b0;
  endtask

  task automatic trace_off(input int r);
    int e;
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    e = edge_no + 1;
    trc_en = 1'b0;
    if (mbits.size() != 0) begin emit_timing(e, r); push(enc_bundle(), r); mbits.delete(); end
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 out_ready = v;
  endtask

  task automatic drain(input int r);
    int n;
    n = 0;
    while (exp_b.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(exp_b.size() == 0 && !out_valid, r, exp_b.size(), 0);
  endtask

  task automatic conds(input logic [5:0] pat, input int r); // oldest first in pat[5]
    for (int i = 5; i >= 0; i--) send(2'd1, pat[i], 1'b0, 32'h100, 32'h0, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check(out_valid == 1'b0, 12, out_valid, 0);
    check(ev_ready == 1'b1, 12, ev_ready, 1);

    // R2 direct branches are silent
    for (int i = 0; i < 3; i++) send(2'd0, 1'b1, 1'b0, 32'h100, 32'h4000, 2);
    drain(2);
    check(nout == 0, 2, nout, 0);

    // R1 full bundles: 0xC0 and 0xB6
    conds(6'b100000, 1);
    conds(6'b011011, 1);
    drain(1);

    // R3 full address, R4 low-16 form, then R3 again on an upper change
    send(2'd2, 1'b0, 1'b0, 32'h200, 32'h12345678, 3);
    send(2'd3, 1'b0, 1'b0, 32'h204, 32'h1234ABCD, 4);
    send(2'd2, 1'b0, 1'b0, 32'h208, 32'h99990000, 3);
    drain(3);

    // R5 partial bundle ahead of target packet; R2 direct mixed in
    send(2'd1, 1'b1, 1'b0, 32'h300, 0, 5);
    send(2'd0, 1'b0, 1'b0, 32'h304, 32'h5555, 2);
    send(2'd1, 1'b0, 1'b0, 32'h308, 0, 5);
    send(2'd2, 1'b0, 1'b0, 32'h30C, 32'h99991111, 5);
    drain(5);

    // R6 short count with a short idle, R7 extension and saturation
    repeat (10) @(negedge clk);
    send(2'd2, 1'b0, 1'b0, 32'h400, 32'h99992222, 6);
    repeat (60) @(negedge clk);
    send(2'd2, 1'b0, 1'b0, 32'h404, 32'h99993333, 7);
    repeat (9000) @(negedge clk);
    send(2'd2, 1'b0, 1'b0, 32'h408, 32'h99994444, 7);
    drain(7);

    // R8 privilege filter
    cfg_user_en = 1'b0;
    send(2'd2, 1'b0, 1'b0, 32'h500, 32'hAAAA0000, 8);
    send(2'd2, 1'b0, 1'b1, 32'h504, 32'hBBBB0000, 8);
    cfg_user_en = 1'b1; cfg_kern_en = 1'b0;
    send(2'd2, 1'b0, 1'b1, 32'h508, 32'hCCCC0000, 8);
    send(2'd2, 1'b0, 1'b0, 32'h50C, 32'hDDDD0000, 8);
    cfg_kern_en = 1'b1;
    drain(8);

    // R9 inclusive window
    cfg_win_lo[31:0] = 32'h1000; cfg_win_hi[31:0] = 32'h1FFF; cfg_win_en = 2'b01;
    send(2'd2, 1'b0, 1'b0, 32'h2000, 32'h11110000, 9);
    send(2'd2, 1'b0, 1'b0, 32'h0FFF, 32'h22220000, 9);
    send(2'd2, 1'b0, 1'b0, 32'h1FFF, 32'h33330000, 9);
    send(2'd2, 1'b0, 1'b0, 32'h1000, 32'h33334444, 9);
    cfg_win_en = 2'b00;
    drain(9);

    // R10 disable flushes the bundle and later events are ignored
    send(2'd1, 1'b1, 1'b0, 32'h600, 0, 10);
    send(2'd1, 1'b1, 1'b0, 32'h604, 0, 10);
    send(2'd1, 1'b0, 1'b0, 32'h608, 0, 10);
    trace_off(10);
    send(2'd2, 1'b0, 1'b0, 32'h60C, 32'h77770000, 10);
    send(2'd1, 1'b1, 1'b0, 32'h610, 0, 10);
    drain(10);
    @(negedge clk); trc_en = 1'b1;
    conds(6'b111111, 10);
    drain(10);

    // R11 overwrite while the consumer stalls
    set_ready(1'b0);
    send(2'd2, 1'b0, 1'b0, 32'h700, 32'h01020304, 11);
    send(2'd2, 1'b0, 1'b0, 32'h704, 32'h05060708, 11);
    send(2'd2, 1'b0, 1'b0, 32'h708, 32'h090A0B0C, 11);
    repeat (30) @(negedge clk);
    check(out_valid == 1'b1, 12, out_valid, 1);
    while (exp_b.size() > DEPTH) begin void'(exp_b.pop_front()); void'(exp_r.pop_front()); end
    set_ready(1'b1);
    drain(11);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule